// File: doc/BRIEF.md
# Handshaked Character Output Port

This block sits on a 32-bit processor bus and drives a character-oriented output device through eight parallel data lines and a Start/Done handshake. Software sees three word registers: a status word, a character word and a command word. The bus writes the character word to send a byte. That write loads the low byte, puts it on the data lines and pulses Start in a single action.

The byte stays on the data lines until the device answers with Done. A ready flag is cleared when Start goes out and set again when Done is accepted. The flag appears in the sign bit of the status word, so a polling driver needs only a load followed by a branch-on-negative. A separate command word sends a one-cycle print-line request to the device.

Top module: `char_out_port`

## Requirements
- R1: After a synchronous active-low reset, the ready flag is 1, `dev_start` and `dev_line` are 0, and `dev_data` is 0.
- R2: A read of word offset 0 (status) returns the ready flag in bit 31 and 0 in bits 30..0. An idle port therefore reads 0x8000_0000 and a busy port reads 0.
- R3: A write to word offset 1 (character) while ready is 1 places bits 7..0 of the written word on `dev_data` from the next cycle on. Bits 31..8 are ignored. A read of offset 1 returns the held byte in bits 7..0 and 0 in bits 31..8.
- R4: An accepted character write raises `dev_start` for exactly one cycle. That cycle is the first cycle in which the new byte is on `dev_data`.
- R5: The ready flag reads 0 from the cycle in which `dev_start` is high.
- R6: While the ready flag is 0, `dev_data` does not change.
- R7: A write to offset 1 while the ready flag is 0 is ignored. It produces no `dev_start` pulse and leaves `dev_data` and the read-back byte unchanged.
- R8: `dev_done` is sampled on the rising clock edge. It sets the ready flag at the first edge where ready is 0 and `dev_start` is low. A Done level during the Start cycle is not accepted.
- R9: A write to word offset 2 (command) with bit 0 set produces a one-cycle `dev_line` pulse in the next cycle. With bit 0 clear it produces none. Offset 2 reads as 0, and a command write does not touch the character channel.
- R10: Reads of offsets other than 0 and 1 return 0, and writes to offsets 3 and above have no effect. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W (4) | Word offset within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| dev_data | output | CHAR_W (8) | Character lines to the device |
| dev_start | output | 1 | One-cycle Start pulse |
| dev_done | input | 1 | Done answer from the device |
| dev_line | output | 1 | One-cycle print-line request |

## Verification
The bench uses the default build: a 4-bit word offset, an 8-bit character and a 32-bit bus. With these values every one of the 16 offsets can be read and written, and every one of the 256 character codes can be sent. Each code goes out with non-zero upper bits and a Done latency that rotates through 1 to 4 idle cycles. Every other code is also rewritten while the port is busy. A Done level held through the Start cycle is checked separately.

// File: rtl/char_out_pkg.sv
// Package: shared constants and types for the character output port.
// Assumes a word-addressed bus; offsets below are word offsets.
package char_out_pkg;
    localparam int unsigned BUS_W = 32;

    // One-hot register select produced by the address decoder
    typedef struct packed {
        logic stat;
        logic chr;
        logic cmd;
    } reg_sel_t;
endpackage

// File: rtl/char_out_decode.sv
// Module: char_out_decode
// Decodes a word offset into one-hot register selects.
// Assumes the three offsets are distinct; unmapped offsets select nothing.
module char_out_decode
    import char_out_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned STAT_OFS = 0,
    parameter int unsigned CHAR_OFS = 1,
    parameter int unsigned CMD_OFS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] CHAR_A = ADDR_W'(CHAR_OFS);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);

    // Compare the offset against each register's offset
    always_comb begin
        sel.stat = (addr == STAT_A);
        sel.chr  = (addr == CHAR_A);
        sel.cmd  = (addr == CMD_A);
    end

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/char_out_chan.sv
// Module: char_out_chan
// Character channel: latches a byte on an accepted write, pulses Start,
// holds the byte and clears Ready until Done is sampled after Start.
// Assumes dev_done is synchronous to clk.
module char_out_chan
    import char_out_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_char,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              dev_done,
    output logic [CHAR_W-1:0] char_q,
    output logic              start_q,
    output logic              ready_q
);
    logic wr_ok;

    // A character write is taken only while the device is idle
    always_comb wr_ok = wr_char & ready_q;

    // Load byte, pulse Start, and track Ready through the handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q  <= '0;
            start_q <= 1'b0;
            ready_q <= 1'b1;
        end else begin
            start_q <= wr_ok;
            if (wr_ok) begin
                char_q  <= wdata[CHAR_W-1:0];
                ready_q <= 1'b0;
            end else if (!ready_q && !start_q && dev_done) begin
                ready_q <= 1'b1;
            end
        end
    end

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !ready_q);
    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_q |=> $stable(char_q));
    // R8
    ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> ($past(dev_done) && !$past(start_q)));
endmodule

// File: rtl/char_out_cmd.sv
// Module: char_out_cmd
// Command register: a write with the line bit set yields a one-cycle
// print-line pulse; the bit clears itself on the following edge.
module char_out_cmd
    import char_out_pkg::*;
#(
    parameter int unsigned LINE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic [BUS_W-1:0] wdata,
    output logic             line_q
);
    // Set on a write carrying the line bit, otherwise clear
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= wr_cmd & wdata[LINE_BIT];
    end

    // R9
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q && !$past(wr_cmd) |=> !line_q);
    // R9
    line_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_q) |-> $past(wr_cmd));
endmodule

// File: rtl/char_out_port.sv
// Module: char_out_port (top)
// Memory-mapped character output port with Start/Done handshake.
// Assumes single-cycle word strobes and a combinational read path.
module char_out_port
    import char_out_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CHAR_W   = 8,
    parameter int unsigned STAT_OFS = 0,
    parameter int unsigned CHAR_OFS = 1,
    parameter int unsigned CMD_OFS  = 2,
    parameter int unsigned LINE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [CHAR_W-1:0] dev_data,
    output logic              dev_start,
    input  logic              dev_done,
    output logic              dev_line
);
    localparam int unsigned SIGN_BIT = BUS_W - 1;

    reg_sel_t          sel;
    logic [CHAR_W-1:0] char_q;
    logic              ready_q;

    char_out_decode #(
        .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS),
        .CHAR_OFS(CHAR_OFS), .CMD_OFS(CMD_OFS)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .sel(sel)
    );

    char_out_chan #(.CHAR_W(CHAR_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr_char(bus_wr & sel.chr), .wdata(bus_wdata),
        .dev_done(dev_done),
        .char_q(char_q), .start_q(dev_start), .ready_q(ready_q)
    );

    char_out_cmd #(.LINE_BIT(LINE_BIT)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd(bus_wr & sel.cmd), .wdata(bus_wdata),
        .line_q(dev_line)
    );

    // Drive the held character to the device
    always_comb dev_data = char_q;

    // Read mux: Ready in the sign bit, byte in the low bits, rest zero
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel.stat)     bus_rdata[SIGN_BIT]   = ready_q;
            else if (sel.chr) bus_rdata[CHAR_W-1:0] = char_q;
        end
    end

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
    // R7
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.chr && !ready_q) |=> (!dev_start && $stable(dev_data)));
    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.chr && ready_q) |=> (dev_data == $past(bus_wdata[CHAR_W-1:0])));
endmodule

// File: tb/test_char_out_port.sv
`timescale 1ns/1ps
module test_char_out_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  dev_data;
    logic        dev_start;
    logic        dev_done = 1'b0;
    logic        dev_line;

    int errors = 0;
    int checks = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    char_out_port i_char_out_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_data(dev_data), .dev_start(dev_start), .dev_done(dev_done),
        .dev_line(dev_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one word; returns 0.5 ns after the capturing edge
    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #0.5;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read one word between edges
    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  last;
        repeat (3) @(posedge clk);
        #0.5;
        // R1 reset state
        chk("R1 start", {31'b0, dev_start}, 0);
        chk("R1 line", {31'b0, dev_line}, 0);
        chk("R1 data", {24'b0, dev_data}, 0);
        @(negedge clk); rst_n = 1'b1;
        bread(4'd0, rd); chk("R1/R2 idle status", rd, 32'h8000_0000);
        // R10 no read strobe gives zero
        #0.5; chk("R10 rd low", bus_rdata, 0);

        // Sweep every character code
        for (int c = 0; c < 256; c++) begin
            int lat;
            lat = 1 + (c % 4);
            bwrite(4'd1, {8'(c * 7 + 3), 8'(~c), 8'(c ^ 8'h5a), 8'(c)});
            chk("R4 start high", {31'b0, dev_start}, 1);
            chk("R3 data", {24'b0, dev_data}, 32'(c));
            bread(4'd0, rd); chk("R5 busy status", rd, 0);
            if (c % 2 == 1) begin
                bwrite(4'd1, 32'(~c));
                chk("R7 no start", {31'b0, dev_start}, 0);
                chk("R7 data kept", {24'b0, dev_data}, 32'(c));
            end else begin
                @(posedge clk); #0.5;
                chk("R4 start one cycle", {31'b0, dev_start}, 0);
            end
            for (int w = 0; w < lat; w++) begin
                @(posedge clk); #0.5;
                chk("R6 hold", {24'b0, dev_data}, 32'(c));
            end
            bread(4'd0, rd); chk("R2 busy before done", rd, 0);
            @(negedge clk); dev_done = 1'b1;
            @(posedge clk); #0.5; dev_done = 1'b0;
            bread(4'd0, rd); chk("R8 ready after done", rd, 32'h8000_0000);
            bread(4'd1, rd); chk("R3 readback", rd, 32'(c));
        end
        last = 8'hff;

        // R8 Done held through the Start cycle is not taken there
        bwrite(4'd1, 32'h0000_0041);
        @(negedge clk); dev_done = 1'b1;
        @(posedge clk); #0.5;
        bread(4'd0, rd); chk("R8 done in start ignored", rd, 0);
        @(posedge clk); #0.5; dev_done = 1'b0;
        bread(4'd0, rd); chk("R8 done after start", rd, 32'h8000_0000);
        last = 8'h41;

        // R9 command register
        bwrite(4'd2, 32'h0000_0001);
        chk("R9 line pulse", {31'b0, dev_line}, 1);
        chk("R9 no start", {31'b0, dev_start}, 0);
        @(posedge clk); #0.5;
        chk("R9 self clear", {31'b0, dev_line}, 0);
        bwrite(4'd2, 32'hffff_fffe);
        chk("R9 bit0 clear", {31'b0, dev_line}, 0);
        bread(4'd2, rd); chk("R9 cmd reads zero", rd, 0);

        // R10 every offset read and unmapped write
        for (int a = 0; a < 16; a++) begin
            logic [31:0] exp;
            exp = (a == 0) ? 32'h8000_0000 : (a == 1) ? {24'b0, last} : 32'h0;
            bread(4'(a), rd); chk("R10 offset read", rd, exp);
            if (a >= 3) begin
                bwrite(4'(a), 32'hffff_ffff);
                chk("R10 write no start", {31'b0, dev_start}, 0);
                chk("R10 write no line", {31'b0, dev_line}, 0);
                chk("R10 write data", {24'b0, dev_data}, {24'b0, last});
            end
        end
        bread(4'd0, rd); chk("R10 status intact", rd, 32'h8000_0000);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule